// File: doc/BRIEF.md
# Descriptor-Fetch Transfer Sequencer

This block carries out one activated memory-to-memory transfer whose whole channel state sits in shared RAM. When it is started with a source number and an 8-bit base page, it first reads a single vector byte. That byte points at an 8-byte descriptor in the same page. The block reads the descriptor, then moves one block of 8-bit or 16-bit units from the source address to the destination address, one unit at a time. After the data it writes the updated descriptor fields back to RAM. The new values of those fields come from an external update unit, which sees the fetched descriptor on dedicated ports.

A descriptor can carry a chain flag. When the flag is set, the descriptor that follows it in RAM is handled within the same activation. When the walk is over, the block raises a one-cycle done pulse. With it comes an interrupt indication that reflects only the first descriptor's count, and an error indication if the chain tried to run past the last descriptor slot. All accesses go over a simple synchronous bus: 16-bit address, byte or halfword size, little-endian halfwords, and read data returned one cycle after the request.

Top module: `desc_xfer_seq`

## Requirements
- R1: When `start` is seen while idle, the first bus access is a byte read at address {`base_hi`, `src_num`}, issued in the cycle after `start`.
- R2: The vector byte V gives the descriptor address {base, V}, which is read as four halfwords at offsets +0, +2, +4 and +6. The byte layout is: +0 control, +1 block size, +2 count, +3 reload, +4/+5 source address (low byte first), +6/+7 destination address (low byte first). These fields appear on the `dsc_*` ports and are held there after done.
- R3: A block-size value of 00h means 256 units. Control bit 0 set selects 16-bit units (halfword accesses); clear selects 8-bit units.
- R4: Each unit is a read at the current source address followed in the next cycle by a write of the same data to the current destination address. The source address advances by the unit size after each unit when control bit 1 is set and stays fixed otherwise. Control bit 2 does the same for the destination address.
- R5: After the block, the block writes back exactly three fields, in this order: `upd_cnt` as a byte at +2, `upd_src` as a halfword at +4, and `upd_dst` as a halfword at +6. The control, block-size and reload bytes are never rewritten.
- R6: When control bit 3 (chain) is set, the descriptor at the current address + 8 is fetched and processed before done. The vector byte is not read again.
- R7: `busy` is high from the cycle after an accepted `start` through the done cycle. For a walk it lasts 3 + Σ(8 + 2·units) cycles, where the sum runs over the processed descriptors. `done` is a single-cycle pulse.
- R8: `irq` is high together with `done` exactly when the first descriptor's fetched count was 01h. The counts of chained descriptors have no effect.
- R9: If the descriptor at low offset F8h (slot 23) has its chain flag set, it is processed fully, the walk stops, and `err` is high together with `done`.
- R10: A `start` pulse while busy is ignored. The running walk and its results are unchanged.
- R11: Under reset, `busy`, `done`, `irq`, `err` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Activation pulse |
| src_num | input | 8 | Activation source number (vector index) |
| base_hi | input | 8 | Upper address byte of the vector and descriptor page |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle end-of-walk pulse |
| irq | output | 1 | First descriptor's count reached zero (with done) |
| err | output | 1 | Chain ran into the last slot (with done) |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_half | output | 1 | Halfword access when high, byte when low |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data (byte in bits 7:0) |
| mem_rdata | input | 16 | Read data, valid the cycle after the read request |
| dsc_ctrl | output | 8 | Fetched control byte |
| dsc_blk | output | 8 | Fetched block-size byte |
| dsc_cnt | output | 8 | Fetched count byte |
| dsc_rld | output | 8 | Fetched reload byte |
| dsc_src | output | 16 | Fetched source address |
| dsc_dst | output | 16 | Fetched destination address |
| upd_cnt | input | 8 | Updated count from the update unit |
| upd_src | input | 16 | Updated source address from the update unit |
| upd_dst | input | 16 | Updated destination address from the update unit |

## Verification
The assertions assume that `mem_rdata` answers every read in the following cycle, and that vector bytes point at 8-aligned descriptor slots, so descriptor offsets never carry out of the low address byte. They also assume that halfword units use even addresses. The stimulus keeps to these rules by construction. Vector bytes are always 40h + 8·k. Source and destination addresses are drawn as even values inside separate data windows that never touch the descriptor page. The update unit is modelled as a fixed, known function of the fetched fields.

// File: rtl/dxs_pkg.sv
package dxs_pkg;
  localparam int DW = 16;

  // control-byte bit positions
  localparam int CTL_HALF  = 0;
  localparam int CTL_SINC  = 1;
  localparam int CTL_DINC  = 2;
  localparam int CTL_CHAIN = 3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_VEC, ST_LOAD, ST_D0, ST_D1, ST_D2, ST_D3, ST_D4,
    ST_RD, ST_WR, ST_WB0, ST_WB1, ST_WB2, ST_DONE
  } st_e;

  // block-size byte to unit count, 00h standing for 256
  function automatic logic [8:0] unit_total(input logic [7:0] blk);
    return (blk == 8'h00) ? 9'd256 : {1'b0, blk};
  endfunction

  // advance an address by one unit when incrementing is selected
  function automatic logic [15:0] next_addr(input logic [15:0] a,
                                            input logic inc,
                                            input logic half);
    if (!inc) return a;
    return a + (half ? 16'd2 : 16'd1);
  endfunction
endpackage

// File: rtl/dxs_desc_regs.sv
module dxs_desc_regs
  import dxs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_cb,
  input  logic          cap_cr,
  input  logic          cap_sa,
  input  logic          cap_da,
  input  logic [DW-1:0] rdata,
  output logic [7:0]    ctrl,
  output logic [7:0]    blk,
  output logic [7:0]    cnt,
  output logic [7:0]    rld,
  output logic [15:0]   sa,
  output logic [15:0]   da
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0; blk <= '0; cnt <= '0; rld <= '0; sa <= '0; da <= '0;
    end else begin
      if (cap_cb) begin ctrl <= rdata[7:0]; blk <= rdata[15:8]; end
      if (cap_cr) begin cnt  <= rdata[7:0]; rld <= rdata[15:8]; end
      if (cap_sa) sa <= rdata;
      if (cap_da) da <= rdata;
    end
  end
endmodule

// File: rtl/dxs_walker.sv
module dxs_walker
  import dxs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        step,
  input  logic        half,
  input  logic        sinc,
  input  logic        dinc,
  input  logic [7:0]  blk,
  input  logic [15:0] sa_in,
  input  logic [15:0] da_in,
  output logic [15:0] cur_sa,
  output logic [15:0] cur_da,
  output logic        last_unit
);
  logic [8:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_sa <= '0; cur_da <= '0; left <= '0;
    end else if (load) begin
      cur_sa <= sa_in;
      cur_da <= da_in;
      left   <= unit_total(blk);
    end else if (step) begin
      cur_sa <= next_addr(cur_sa, sinc, half);
      cur_da <= next_addr(cur_da, dinc, half);
      left   <= left - 9'd1;
    end
  end

  assign last_unit = (left == 9'd1);
endmodule

// File: rtl/desc_xfer_seq.sv
module desc_xfer_seq
  import dxs_pkg::*;
#(
  parameter int BASE_W     = 8,
  parameter int LOW_W      = 8,
  parameter int NDESC      = 24,
  parameter int DESC_BYTES = 8,
  parameter int DESC_OFS   = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LOW_W-1:0]        src_num,
  input  logic [BASE_W-1:0]       base_hi,
  output logic                    busy,
  output logic                    done,
  output logic                    irq,
  output logic                    err,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic                    mem_half,
  output logic [BASE_W+LOW_W-1:0] mem_addr,
  output logic [DW-1:0]           mem_wdata,
  input  logic [DW-1:0]           mem_rdata,
  output logic [7:0]              dsc_ctrl,
  output logic [7:0]              dsc_blk,
  output logic [7:0]              dsc_cnt,
  output logic [7:0]              dsc_rld,
  output logic [15:0]             dsc_src,
  output logic [15:0]             dsc_dst,
  input  logic [7:0]              upd_cnt,
  input  logic [15:0]             upd_src,
  input  logic [15:0]             upd_dst
);
  localparam logic [LOW_W-1:0] LAST_LOW = LOW_W'(DESC_OFS + (NDESC - 1) * DESC_BYTES);
  localparam logic [LOW_W-1:0] SLOT     = LOW_W'(DESC_BYTES);

  st_e               st;
  logic [BASE_W-1:0] base_q;
  logic [LOW_W-1:0]  src_q;
  logic [LOW_W-1:0]  dlo;
  logic              first_q, term_q, err_q;

  // named internal events, observed by the checker
  logic data_rd, data_wr, wb_first, walk_load, last_unit;
  logic [15:0] cur_sa, cur_da;

  assign data_rd   = (st == ST_RD);
  assign data_wr   = (st == ST_WR);
  assign wb_first  = (st == ST_WB0);
  assign walk_load = (st == ST_D4);

  dxs_desc_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .cap_cb(st == ST_D1), .cap_cr(st == ST_D2),
    .cap_sa(st == ST_D3), .cap_da(st == ST_D4),
    .rdata(mem_rdata),
    .ctrl(dsc_ctrl), .blk(dsc_blk), .cnt(dsc_cnt), .rld(dsc_rld),
    .sa(dsc_src), .da(dsc_dst)
  );

  dxs_walker u_walk (
    .clk(clk), .rst_n(rst_n),
    .load(walk_load), .step(data_wr),
    .half(dsc_ctrl[CTL_HALF]), .sinc(dsc_ctrl[CTL_SINC]), .dinc(dsc_ctrl[CTL_DINC]),
    .blk(dsc_blk), .sa_in(dsc_src), .da_in(mem_rdata),
    .cur_sa(cur_sa), .cur_da(cur_da), .last_unit(last_unit)
  );

  // sequence control
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; base_q <= '0; src_q <= '0; dlo <= '0;
      first_q <= 1'b0; term_q <= 1'b0; err_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          base_q <= base_hi; src_q <= src_num;
          first_q <= 1'b1; term_q <= 1'b0; err_q <= 1'b0;
          st <= ST_VEC;
        end
        ST_VEC:  st <= ST_LOAD;
        ST_LOAD: begin dlo <= mem_rdata[LOW_W-1:0]; st <= ST_D0; end
        ST_D0:   st <= ST_D1;
        ST_D1:   st <= ST_D2;
        ST_D2:   st <= ST_D3;
        ST_D3:   st <= ST_D4;
        ST_D4:   st <= ST_RD;
        ST_RD:   st <= ST_WR;
        ST_WR:   st <= last_unit ? ST_WB0 : ST_RD;
        ST_WB0: begin
          if (first_q) term_q <= (dsc_cnt == 8'h01);
          st <= ST_WB1;
        end
        ST_WB1:  st <= ST_WB2;
        ST_WB2: begin
          first_q <= 1'b0;
          if (!dsc_ctrl[CTL_CHAIN]) st <= ST_DONE;
          else if (dlo == LAST_LOW) begin err_q <= 1'b1; st <= ST_DONE; end
          else begin dlo <= dlo + SLOT; st <= ST_D0; end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // bus drive
  always_comb begin
    mem_req = 1'b0; mem_we = 1'b0; mem_half = 1'b0;
    mem_addr = '0; mem_wdata = '0;
    case (st)
      ST_VEC: begin mem_req = 1'b1; mem_addr = {base_q, src_q}; end
      ST_D0, ST_D1, ST_D2, ST_D3: begin
        mem_req = 1'b1; mem_half = 1'b1;
        mem_addr = {base_q, dlo + LOW_W'(2 * (int'(st) - int'(ST_D0)))};
      end
      ST_RD: begin
        mem_req = 1'b1; mem_half = dsc_ctrl[CTL_HALF]; mem_addr = cur_sa;
      end
      ST_WR: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_half = dsc_ctrl[CTL_HALF];
        mem_addr = cur_da; mem_wdata = mem_rdata;
      end
      ST_WB0: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = {base_q, dlo + LOW_W'(2)}; mem_wdata = {8'h00, upd_cnt};
      end
      ST_WB1: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_half = 1'b1;
        mem_addr = {base_q, dlo + LOW_W'(4)}; mem_wdata = upd_src;
      end
      ST_WB2: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_half = 1'b1;
        mem_addr = {base_q, dlo + LOW_W'(6)}; mem_wdata = upd_dst;
      end
      default: ;
    endcase
  end

  assign busy = (st != ST_IDLE);
  assign done = (st == ST_DONE);
  assign irq  = done & term_q;
  assign err  = done & err_q;
endmodule

// File: rtl/desc_xfer_seq_chk.sv
module desc_xfer_seq_chk #(
  parameter int BASE_W = 8,
  parameter int LOW_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic [LOW_W-1:0]        src_num,
  input logic [BASE_W-1:0]       base_hi,
  input logic                    busy,
  input logic                    done,
  input logic                    irq,
  input logic                    err,
  input logic                    mem_req,
  input logic                    mem_we,
  input logic                    mem_half,
  input logic [BASE_W+LOW_W-1:0] mem_addr,
  input logic                    data_rd,
  input logic                    data_wr,
  input logic                    wb_first
);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  a_r1_vector_first: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (mem_req && !mem_we && !mem_half &&
                          mem_addr == {$past(base_hi), $past(src_num)}));

  a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |-> ($past(data_rd) && mem_req && mem_we));

  a_r5_wb_order: assert property (@(posedge clk) disable iff (!rst_n)
    wb_first |=> (mem_req && mem_we && mem_half && mem_addr[2:0] == 3'd4));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> done);

  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> busy);
endmodule

bind desc_xfer_seq desc_xfer_seq_chk #(.BASE_W(BASE_W), .LOW_W(LOW_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .src_num(src_num), .base_hi(base_hi),
  .busy(busy), .done(done), .irq(irq), .err(err),
  .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half), .mem_addr(mem_addr),
  .data_rd(data_rd), .data_wr(data_wr), .wb_first(wb_first)
);

// File: tb/desc_xfer_seq_test.sv
module desc_xfer_seq_test;
  localparam logic [7:0] BASE = 8'h0E;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, start, busy, done, irq, err;
  logic [7:0] src_num, base_hi;
  logic mem_req, mem_we, mem_half;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0] dsc_ctrl, dsc_blk, dsc_cnt, dsc_rld, upd_cnt;
  logic [15:0] dsc_src, dsc_dst, upd_src, upd_dst;

  int nchk = 0, nfail = 0;

  // update unit stand-in: a fixed, known function of the fetched fields
  assign upd_cnt = dsc_cnt - 8'd1;
  assign upd_src = dsc_src + 16'h0100;
  assign upd_dst = dsc_dst + 16'h0200;

  desc_xfer_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_num(src_num), .base_hi(base_hi),
    .busy(busy), .done(done), .irq(irq), .err(err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_half(mem_half), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dsc_ctrl(dsc_ctrl), .dsc_blk(dsc_blk), .dsc_cnt(dsc_cnt), .dsc_rld(dsc_rld),
    .dsc_src(dsc_src), .dsc_dst(dsc_dst),
    .upd_cnt(upd_cnt), .upd_src(upd_src), .upd_dst(upd_dst)
  );

  // 4 KB memory, one-cycle read latency
  logic [7:0] mem [4096];
  logic [7:0] shadow [4096];
  logic tb_we = 1'b0;
  logic [11:0] tb_a = '0;
  logic [7:0] tb_d = '0;
  logic [15:0] rdata_q = '0;
  assign mem_rdata = rdata_q;

  always @(posedge clk) begin
    if (tb_we) mem[tb_a] <= tb_d;
    if (mem_req && mem_we) begin
      mem[mem_addr[11:0]] <= mem_wdata[7:0];
      if (mem_half) mem[mem_addr[11:0] + 12'd1] <= mem_wdata[15:8];
    end
    if (mem_req && !mem_we)
      rdata_q <= mem_half ? {mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]}
                          : {8'h00, mem[mem_addr[11:0]]};
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_a = a; tb_d = d;
    shadow[a] = d;
  endtask

  task automatic put_end();
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic put_desc(input int k, input logic [7:0] c, input logic [7:0] b,
                          input logic [7:0] n, input logic [7:0] r,
                          input logic [15:0] s, input logic [15:0] d);
    logic [11:0] a;
    a = 12'hE40 + 12'(8 * k);
    put(a, c); put(a + 1, b); put(a + 2, n); put(a + 3, r);
    put(a + 4, s[7:0]); put(a + 5, s[15:8]); put(a + 6, d[7:0]); put(a + 7, d[15:8]);
  endtask

  task automatic fill(input logic [15:0] s, input int len);
    for (int i = 0; i < len; i++) put(s[11:0] + 12'(i), 8'($urandom));
  endtask

  // reference walk on the shadow image
  task automatic model(input logic [7:0] src, output bit e_irq, output bit e_err,
                       output int e_cyc, output logic [7:0] e_cnt,
                       output logic [15:0] e_sa);
    logic [11:0] a;
    logic [7:0] c, b, n;
    logic [15:0] s, d, ps, pd;
    int u;
    bit first;
    e_irq = 0; e_err = 0; e_cyc = 3; first = 1;
    a = {BASE[3:0], shadow[{BASE[3:0], src}]};
    forever begin
      c = shadow[a]; b = shadow[a + 1]; n = shadow[a + 2];
      s = {shadow[a + 5], shadow[a + 4]}; d = {shadow[a + 7], shadow[a + 6]};
      e_cnt = n; e_sa = s;
      u = (b == 0) ? 256 : int'(b);
      ps = s; pd = d;
      for (int i = 0; i < u; i++) begin
        shadow[pd[11:0]] = shadow[ps[11:0]];
        if (c[0]) shadow[pd[11:0] + 12'd1] = shadow[ps[11:0] + 12'd1];
        if (c[1]) ps = ps + (c[0] ? 16'd2 : 16'd1);
        if (c[2]) pd = pd + (c[0] ? 16'd2 : 16'd1);
      end
      shadow[a + 2] = n - 8'd1;
      {shadow[a + 5], shadow[a + 4]} = s + 16'h0100;
      {shadow[a + 7], shadow[a + 6]} = d + 16'h0200;
      if (first && n == 8'h01) e_irq = 1;
      first = 0;
      e_cyc += 8 + 2 * u;
      if (!c[3]) break;
      if (a[7:0] == 8'hF8) begin e_err = 1; break; end
      a = a + 12'd8;
    end
  endtask

  task automatic activate(input logic [7:0] src, input bit poke);
    bit e_irq, e_err, g_irq, g_err, got, ended;
    int e_cyc, bc, bad;
    logic [7:0] e_cnt, g_cnt;
    logic [15:0] e_sa, g_sa;
    model(src, e_irq, e_err, e_cyc, e_cnt, e_sa);
    @(negedge clk);
    start = 1'b1; src_num = src;
    @(negedge clk);
    start = 1'b0; src_num = 8'($urandom);
    chk(mem_req && !mem_we && !mem_half && mem_addr == {BASE, src},
        "R1 vector read address", int'(mem_addr), int'({BASE, src}));
    bc = 0; got = 0; ended = 0; g_irq = 0; g_err = 0; g_cnt = '0; g_sa = '0;
    for (int k = 0; k < 3000; k++) begin
      if (busy) bc++;
      if (done) begin
        got = 1; g_irq = irq; g_err = err; g_cnt = dsc_cnt; g_sa = dsc_src;
      end
      if (!busy) begin ended = 1; break; end
      if (poke && k == 4) begin start = 1'b1; src_num = src + 8'd1; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(ended && got, "R7 walk ended with done", int'(got), 1);
    chk(bc == e_cyc, poke ? "R10 busy length with ignored start" : "R7 R3 busy length", bc, e_cyc);
    chk(g_irq == e_irq, "R8 irq", int'(g_irq), int'(e_irq));
    chk(g_err == e_err, "R9 err", int'(g_err), int'(e_err));
    chk(g_cnt == e_cnt && g_sa == e_sa, "R2 descriptor fields on ports", int'(g_sa), int'(e_sa));
    bad = 0;
    for (int i = 0; i < 4096; i++) if (mem[i] !== shadow[i]) bad++;
    chk(bad == 0, "R4 R5 R6 memory image", bad, 0);
  endtask

  initial begin
    #1_900_000;
    nfail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; start = 1'b0; src_num = '0; base_hi = BASE;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !irq && !err && !mem_req, "R11 reset outputs", int'(busy), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4096; i++) put(12'(i), 8'h00);
    put_end();

    // R3: 256 byte units, then 256 halfword units
    put(12'hE05, 8'h40); put_desc(0, 8'h06, 8'h00, 8'h09, 8'h00, 16'h0100, 16'h0600);
    fill(16'h0100, 512); put_end();
    activate(8'h05, 0);
    put_desc(0, 8'h07, 8'h00, 8'h01, 8'h00, 16'h0100, 16'h0600); put_end();
    activate(8'h05, 0);

    // R4: both addresses fixed
    put(12'hE07, 8'h48); put_desc(1, 8'h00, 8'h04, 8'h03, 8'h02, 16'h0200, 16'h0700);
    fill(16'h0200, 4); put_end();
    activate(8'h07, 0);

    // R8: chained second count of 1 gives no irq; first count of 1 does
    put(12'hE09, 8'h50);
    put_desc(2, 8'h0E, 8'h02, 8'h05, 8'h00, 16'h0300, 16'h0800);
    put_desc(3, 8'h06, 8'h03, 8'h01, 8'h00, 16'h0310, 16'h0810); put_end();
    activate(8'h09, 0);
    put_desc(2, 8'h0F, 8'h02, 8'h01, 8'h00, 16'h0300, 16'h0800);
    put_desc(3, 8'h06, 8'h03, 8'h05, 8'h00, 16'h0310, 16'h0810); put_end();
    activate(8'h09, 0);

    // R9: chain into slot 23, and slot 23 alone with chain set
    put(12'hE0B, 8'hF0);
    put_desc(22, 8'h0A, 8'h02, 8'h04, 8'h00, 16'h0400, 16'h0900);
    put_desc(23, 8'h0F, 8'h02, 8'h04, 8'h00, 16'h0410, 16'h0910); put_end();
    activate(8'h0B, 0);
    put(12'hE0C, 8'hF8); put_end();
    activate(8'h0C, 0);

    // R10: start pulse while busy is ignored
    put(12'hE0D, 8'h60); put_desc(4, 8'h07, 8'h05, 8'h02, 8'h00, 16'h0420, 16'h0A00);
    put(12'hE0E, 8'h68); put_desc(5, 8'h06, 8'h01, 8'h01, 8'h00, 16'h0440, 16'h0A40);
    fill(16'h0420, 16); put_end();
    activate(8'h0D, 1);

    // random walks, R6 chains of up to three descriptors
    for (int t = 0; t < 30; t++) begin
      int len, k;
      logic [7:0] src;
      len = 1 + int'($urandom % 3);
      k = int'($urandom % (25 - len));
      src = 8'(1 + $urandom % 39);
      put({BASE[3:0], src}, 8'(8'h40 + 8 * k));
      for (int j = 0; j < len; j++) begin
        logic [7:0] c, n;
        logic [15:0] s, d;
        c = (8'($urandom) & 8'hF7) | ((j < len - 1) ? 8'h08 : 8'h00);
        n = ($urandom % 3 == 0) ? 8'h01 : 8'($urandom);
        s = 16'h0100 + 16'($urandom % 512) * 16'd2;
        d = 16'h0600 + 16'($urandom % 768) * 16'd2;
        put_desc(k + j, c, 8'(1 + $urandom % 8), n, 8'($urandom), s, d);
        fill(s, 16);
      end
      put_end();
      activate(src, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule